// File: doc/BRIEF.md
# Embedded Timing Code Decoder for 4:2:2 Byte Streams

This block watches a single byte-wide 4:2:2 video stream, one byte per rising edge of the double-rate clock. It finds embedded timing codes in that stream and rebuilds the video timing from them alone. A timing code is three marker bytes (all ones, all zeros, all zeros) followed by one status byte. The status byte carries the field bit, the vertical-blanking bit and the start/end-of-active-video bit. Its four low bits are protection bits and are not checked.

From each accepted code the block updates its registered flags. It drives a blanking output that opens at start-of-active-video on active lines and closes at end-of-active-video. It pulses a code-detected strobe, and a line-start strobe on every start-of-active-video code. While the line is active, it splits the bytes that follow into chroma-blue, luma, chroma-red and second luma samples. Each sample carries a kind tag and a valid strobe. No external sync or blank pin is consulted.

Top module: `bt656_trs_decoder`

## Requirements
- R1: The marker bytes 0xFF, 0x00, 0x00, followed by a status byte whose bit 7 is 1, raise `code_det` for exactly one cycle. That cycle begins at the clock edge that captures the status byte.
- R2: A status byte with bit 7 clear does not raise `code_det` and leaves every flag and `blank_o` unchanged. The marker search then restarts. Status bits 3:0 (protection) may take any value and do not affect acceptance.
- R3: On an accepted code, `field_o` takes status bit 6 (0 is field 1, 1 is field 2), `v_flag` takes bit 5 and `h_flag` takes bit 4. All three change at the same edge as `code_det`.
- R4: `blank_o` goes to 1 on a code with H=1 (end of active video). It goes to 0 on a code with H=0 (start of active video) only when V=0, so it stays 1 for the whole of any line with V=1. `v_flag` = 1 always implies `blank_o` = 1.
- R5: `field_o` changes only at an accepted code. A broken or partial marker run never moves it.
- R6: `line_start` pulses for one cycle together with `code_det` on every accepted code with H=0, and at no other time.
- R7: While `blank_o` is 0, each data byte produces `sample_o` with `sample_vld` high one cycle after capture. `sample_kind` repeats the order 0 (Cb), 1 (Y), 2 (Cr), 3 (Y'), and restarts at 0 after each start-of-active-video code. No sample is produced while `blank_o` is 1.
- R8: The bytes of an end-of-active-video code (0xFF, 0x00, 0x00, status) are never emitted as samples.
- R9: After reset: `blank_o` = 1, `field_o` = 0, `v_flag` = 1, `h_flag` = 1, and `code_det`, `line_start` and `sample_vld` are 0.
- R10: A 0xFF byte at any point inside a marker run restarts the run at its first byte, so 0xFF 0xFF 0x00 0x00 followed by a status byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | DATA_W | Incoming stream byte |
| code_det | output | 1 | One-cycle strobe for an accepted timing code |
| field_o | output | 1 | Current field (0 field 1, 1 field 2) |
| v_flag | output | 1 | Vertical-blanking flag of the last code |
| h_flag | output | 1 | End-of-active flag of the last code |
| blank_o | output | 1 | Regenerated blanking |
| line_start | output | 1 | Strobe on start-of-active-video codes |
| sample_o | output | DATA_W | Demultiplexed active sample |
| sample_kind | output | 2 | 0 Cb, 1 Y, 2 Cr, 3 Y' |
| sample_vld | output | 1 | Sample strobe |

## Verification
The stream is driven with a complete active line, a vertical-blanking line, a code whose status byte has bit 7 clear, and marker runs broken by a stray byte. It also carries a marker run with a doubled 0xFF and a code with unusual protection bits. The active line separates correct sample ordering and EAV suppression from leaking marker bytes. The blanking line separates V-gated blanking from H-only blanking. The broken runs and the bad status byte show that the field and flags move only on a true code. The doubled 0xFF shows whether the search restarts correctly.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

   typedef enum logic [1:0] {
      SEEK_IDLE = 2'd0,
      SEEK_ONE  = 2'd1,
      SEEK_TWO  = 2'd2,
      SEEK_STAT = 2'd3
   } seek_state_e;

   typedef enum logic [1:0] {
      SK_CB = 2'd0,
      SK_Y0 = 2'd1,
      SK_CR = 2'd2,
      SK_Y1 = 2'd3
   } smp_kind_e;

   localparam int unsigned MIN_DATA_W = 8;

endpackage

// File: rtl/bt656_trs_seeker.sv
module bt656_trs_seeker
   import bt656_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic              hit,
   output logic              st_f,
   output logic              st_v,
   output logic              st_h,
   output logic              ctrl_byte
);

   localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] ALL_ZEROS = {DATA_W{1'b0}};
   localparam int unsigned       MSB       = DATA_W - 1;

   seek_state_e state_q, state_d;
   logic        is_ones, is_zeros;

   assign is_ones  = (din == ALL_ONES);
   assign is_zeros = (din == ALL_ZEROS);

   always_comb begin
      state_d = SEEK_IDLE;
      unique case (state_q)
         SEEK_IDLE: state_d = is_ones ? SEEK_ONE : SEEK_IDLE;
         SEEK_ONE:  state_d = is_zeros ? SEEK_TWO : (is_ones ? SEEK_ONE : SEEK_IDLE);
         SEEK_TWO:  state_d = is_zeros ? SEEK_STAT : (is_ones ? SEEK_ONE : SEEK_IDLE);
         SEEK_STAT: state_d = is_ones ? SEEK_ONE : SEEK_IDLE;
         default:   state_d = SEEK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEEK_IDLE;
      else        state_q <= state_d;
   end

   // status byte: top bit marks a real code, then field, vblank, end-of-active
   assign hit       = (state_q == SEEK_STAT) && din[MSB];
   assign st_f      = din[MSB-1];
   assign st_v      = din[MSB-2];
   assign st_h      = din[MSB-3];
   assign ctrl_byte = (state_q != SEEK_IDLE) || is_ones;

endmodule

// File: rtl/bt656_frame_timing.sv
module bt656_frame_timing (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic st_f,
   input  logic st_v,
   input  logic st_h,
   output logic code_det,
   output logic field_o,
   output logic v_flag,
   output logic h_flag,
   output logic blank_o,
   output logic line_start
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_det   <= 1'b0;
         line_start <= 1'b0;
         field_o    <= 1'b0;
         v_flag     <= 1'b1;
         h_flag     <= 1'b1;
         blank_o    <= 1'b1;
      end else begin
         code_det   <= hit;
         line_start <= hit && !st_h;
         if (hit) begin
            field_o <= st_f;
            v_flag  <= st_v;
            h_flag  <= st_h;
            // end of active always blanks; start of active opens only on active lines
            blank_o <= st_h | st_v;
         end
      end
   end

endmodule

// File: rtl/bt656_sample_demux.sv
module bt656_sample_demux
   import bt656_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              blank,
   input  logic              ctrl_byte,
   input  logic              sav_hit,
   output logic [DATA_W-1:0] sample_o,
   output logic [1:0]        sample_kind,
   output logic              sample_vld
);

   smp_kind_e phase_q;
   logic      take;

   assign take = !blank && !ctrl_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= SK_CB;
         sample_o    <= '0;
         sample_kind <= 2'd0;
         sample_vld  <= 1'b0;
      end else begin
         sample_vld <= take;
         if (sav_hit) begin
            phase_q <= SK_CB;
         end else if (take) begin
            sample_o    <= din;
            sample_kind <= phase_q;
            phase_q     <= smp_kind_e'(phase_q + 2'd1);
         end
      end
   end

endmodule

// File: rtl/bt656_trs_decoder.sv
module bt656_trs_decoder
   import bt656_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic              code_det,
   output logic              field_o,
   output logic              v_flag,
   output logic              h_flag,
   output logic              blank_o,
   output logic              line_start,
   output logic [DATA_W-1:0] sample_o,
   output logic [1:0]        sample_kind,
   output logic              sample_vld
);

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_width
         $error("bt656_trs_decoder: DATA_W must be at least 8");
      end
   endgenerate

   logic hit, st_f, st_v, st_h, ctrl_byte;

   bt656_trs_seeker #(.DATA_W(DATA_W)) u_seek (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .hit       (hit),
      .st_f      (st_f),
      .st_v      (st_v),
      .st_h      (st_h),
      .ctrl_byte (ctrl_byte)
   );

   bt656_frame_timing u_timing (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit),
      .st_f       (st_f),
      .st_v       (st_v),
      .st_h       (st_h),
      .code_det   (code_det),
      .field_o    (field_o),
      .v_flag     (v_flag),
      .h_flag     (h_flag),
      .blank_o    (blank_o),
      .line_start (line_start)
   );

   bt656_sample_demux #(.DATA_W(DATA_W)) u_demux (
      .clk         (clk),
      .rst_n       (rst_n),
      .din         (din),
      .blank       (blank_o),
      .ctrl_byte   (ctrl_byte),
      .sav_hit     (hit && !st_h),
      .sample_o    (sample_o),
      .sample_kind (sample_kind),
      .sample_vld  (sample_vld)
   );

endmodule

// File: rtl/bt656_trs_chk.sv
module bt656_trs_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] din,
   input logic              code_det,
   input logic              field_o,
   input logic              v_flag,
   input logic              h_flag,
   input logic              blank_o,
   input logic              line_start,
   input logic              sample_vld
);

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      code_det |=> !code_det); // R1

   AST_CODE_HAS_MARKERS: assert property (@(posedge clk) disable iff (!rst_n)
      code_det |-> ($past(din, 4) == {DATA_W{1'b1}}) && ($past(din, 3) == '0)
                   && ($past(din, 2) == '0) && $past(din[DATA_W-1])); // R2

   AST_FIELD_ONLY_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !code_det |-> $stable(field_o)); // R5

   AST_VBLANK_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      v_flag |-> blank_o); // R4

   AST_LINE_START_SAV: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |-> code_det && !h_flag); // R6

   AST_NO_SAMPLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |-> !blank_o); // R7

endmodule

bind bt656_trs_decoder bt656_trs_chk #(.DATA_W(DATA_W)) u_trs_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .din        (din),
   .code_det   (code_det),
   .field_o    (field_o),
   .v_flag     (v_flag),
   .h_flag     (h_flag),
   .blank_o    (blank_o),
   .line_start (line_start),
   .sample_vld (sample_vld)
);

// File: tb/test_bt656_trs_decoder.sv
module test_bt656_trs_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] din = 8'h10;
   logic       code_det, field_o, v_flag, h_flag, blank_o, line_start, sample_vld;
   logic [7:0] sample_o;
   logic [1:0] sample_kind;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bt656_trs_decoder #(.DATA_W(8)) i_bt656_trs_decoder (
      .clk (clk), .rst_n (rst_n), .din (din),
      .code_det (code_det), .field_o (field_o), .v_flag (v_flag), .h_flag (h_flag),
      .blank_o (blank_o), .line_start (line_start), .sample_o (sample_o),
      .sample_kind (sample_kind), .sample_vld (sample_vld)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // present one byte; outputs reflecting its capture are settled on return
   task automatic send(input logic [7:0] b);
      @(negedge clk);
      din = b;
      @(posedge clk);
      #1;
   endtask

   task automatic send_code(input logic [7:0] st);
      send(8'hFF); send(8'h00); send(8'h00); send(st);
   endtask

   task automatic t_reset;
      check("R9 blank", blank_o, 1);
      check("R9 field", field_o, 0);
      check("R9 vflag", v_flag, 1);
      check("R9 hflag", h_flag, 1);
      check("R9 code_det", code_det, 0);
      check("R9 line_start", line_start, 0);
      check("R9 sample_vld", sample_vld, 0);
   endtask

   task automatic t_active_line;
      send(8'h10); send(8'h10);
      send_code(8'h9D);
      check("R1 code_det on EAV", code_det, 1);
      check("R3 hflag", h_flag, 1);
      check("R3 vflag", v_flag, 0);
      check("R4 blank after EAV", blank_o, 1);
      check("R6 no line_start on EAV", line_start, 0);
      send(8'h10);
      check("R1 single-cycle strobe", code_det, 0);
      send_code(8'h80);
      check("R1 code_det on SAV", code_det, 1);
      check("R6 line_start on SAV", line_start, 1);
      check("R4 blank opens on active SAV", blank_o, 0);
      check("R3 hflag SAV", h_flag, 0);
      for (int i = 0; i < 8; i++) begin
         send(8'h40 + 8'(i * 3));
         check("R7 sample_vld", sample_vld, 1);
         check("R7 sample_kind", sample_kind, i % 4);
         check("R7 sample value", sample_o, 8'h40 + 8'(i * 3));
      end
      send(8'hFF); check("R8 no sample on FF", sample_vld, 0);
      send(8'h00); check("R8 no sample on 00", sample_vld, 0);
      send(8'h00); check("R8 no sample on 00", sample_vld, 0);
      send(8'h9D); check("R8 no sample on status", sample_vld, 0);
      check("R4 blank after EAV", blank_o, 1);
   endtask

   task automatic t_vblank_line;
      send_code(8'hAB);
      check("R3 vflag set", v_flag, 1);
      check("R4 blank held on V=1 SAV", blank_o, 1);
      check("R6 line_start on blanking SAV", line_start, 1);
      for (int i = 0; i < 3; i++) begin
         send(8'h40);
         check("R7 no samples in vblank", sample_vld, 0);
      end
      send_code(8'hB6);
      check("R4 blank after vblank EAV", blank_o, 1);
   endtask

   task automatic t_bad_status;
      send_code(8'h5C);
      check("R2 no strobe bit7 clear", code_det, 0);
      check("R2 field unchanged", field_o, 0);
      check("R2 vflag unchanged", v_flag, 1);
      check("R2 hflag unchanged", h_flag, 1);
      send_code(8'hC7);
      check("R2 search restarted", code_det, 1);
      check("R3 field 2", field_o, 1);
      check("R4 active SAV opens", blank_o, 0);
      send_code(8'hDA);
      check("R4 blank on field-2 EAV", blank_o, 1);
   endtask

   task automatic t_broken_runs;
      send(8'hFF); send(8'h00); send(8'h55); send(8'h00); send(8'h00); send(8'h9D);
      check("R5 no code after broken run", code_det, 0);
      check("R5 field held", field_o, 1);
      send(8'h00); send(8'h00); send(8'h80);
      check("R5 no code without FF", code_det, 0);
      check("R5 field held", field_o, 1);
      check("R5 blank held", blank_o, 1);
   endtask

   task automatic t_restart_and_prot;
      send(8'hFF); send(8'hFF); send(8'h00); send(8'h00); send(8'h8F);
      check("R10 doubled FF accepted", code_det, 1);
      check("R2 protection ignored field", field_o, 0);
      check("R10 blank opens", blank_o, 0);
      send(8'h21);
      check("R7 kind restarts Cb", sample_kind, 0);
      check("R7 first sample", sample_o, 8'h21);
      send(8'h22);
      check("R7 second kind Y", sample_kind, 1);
      send_code(8'h9D);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset;
      @(negedge clk);
      rst_n = 1'b1;
      t_active_line;
      t_vblank_line;
      t_bad_status;
      t_broken_runs;
      t_restart_and_prot;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL R9 watchdog actual=timeout expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule